// File: doc/BRIEF.md
# In-Place Halving-Stride Summation Engine

The engine adds up `N` unsigned integer words held in a small local register file, reusing that same storage for every partial sum. While the engine is idle, the host fills the buffer through a single write port. A one-cycle `start` pulse then launches `log2(N)` passes, and each pass takes one clock. In a pass, a fixed array of `N/2` adder lanes reads pairs of slots one stride apart. Every active lane writes its pair's sum back into the lower slot of the pair. Every slot is a register, so all of a pass's writes land on the same clock edge, and the next pass reads only finished results. The clock edge acts as the barrier between passes.

Two stride schedules are available, and each run latches its choice at `start`. The halving schedule begins at `N/2` and shrinks to 1, so the active lanes are always a contiguous block at the low end. The interleaved schedule begins at 1 and doubles, so the active lanes are spread out at growing spacing. This second schedule exists to compare lane occupancy against the first. Lanes are grouped in fixed-size groups. During every pass the engine reports how many groups have no active lane and how many are only partly busy. After the last pass it pulses `done` for one cycle, and `total` shows slot 0, which holds the complete sum.

Top module: `tree_sum_engine`

The controller has three states:
- `ST_IDLE` moves to `ST_PASS` when `start` is high.
- `ST_PASS` stays in `ST_PASS` until the last stride, then moves to `ST_DONE`.
- `ST_DONE` always moves back to `ST_IDLE` after one cycle.

## Requirements
- R1: After reset, `busy`, `done` and `pass_valid` are 0, `total` is 0, and both group counts are 0.
- R2: While `busy` is 0, a cycle with `wr_en` high stores `wr_data`, zero-extended, in slot `wr_addr`. `total` always shows slot 0, so a write to address 0 appears on `total` in the following cycle, and a write to any other address leaves `total` unchanged.
- R3: After a run, `total` equals the exact sum of the `N` loaded words. `total` is `DATA_W + log2(N)` bits wide, so even all-ones inputs cannot overflow.
- R4: When `start` is high in a cycle where `busy` is 0, `busy` and `pass_valid` are 1 from the next cycle on. `pass_valid` stays high for exactly `log2(N)` cycles. In the following cycle `done` is 1 with `pass_valid` at 0, and one cycle after that `busy` returns to 0.
- R5: With `sweep_mode` = 0 (halving), pass k uses stride `N/2 >> k`, and lane t is active when t < stride.
- R6: With `sweep_mode` = 1 (interleaved), pass k uses stride `1 << k`. Lane t works on element 2t and is active when 2t mod (2·stride) = 0. The final sum is the same as in halving mode.
- R7: Lanes t = g·`GROUP` … g·`GROUP`+`GROUP`−1 form group g. During each pass, `groups_idle` counts the groups with no active lane and `groups_partial` counts the groups with some, but not all, lanes active. Both are 0 whenever `pass_valid` is 0.
- R8: While `busy` is 1, `start` and `wr_en` are ignored: neither the pass schedule nor the final `total` changes.
- R9: `done` is high for one cycle only.
- R10: `sweep_mode` is sampled only when a run is accepted, and changing it during a run has no effect on that run's group counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Buffer write strobe (honoured only when idle) |
| wr_addr | input | log2(N) | Slot to write |
| wr_data | input | DATA_W | Word to store |
| sweep_mode | input | 1 | 0 = halving stride, 1 = interleaved stride |
| start | input | 1 | Launch a run (honoured only when idle) |
| busy | output | 1 | Run in progress, including the done cycle |
| done | output | 1 | One-cycle pulse when the total is ready |
| total | output | DATA_W+log2(N) | Contents of slot 0 |
| pass_valid | output | 1 | A pass executes this cycle |
| groups_idle | output | clog2(N/2/GROUP+1) | Groups with no active lane in this pass |
| groups_partial | output | clog2(N/2/GROUP+1) | Groups with some but not all lanes active |

## Verification
The checker assumes that `rst_n` is held low across at least one clock edge. It also assumes that `wr_addr`, `wr_data`, `sweep_mode`, `start` and `wr_en` are never X after reset, so every input is driven to a known level before reset is released. The stimulus changes inputs only on the falling edge, which keeps every input stable around the rising edge that samples it. The bench deliberately pulses `start` and `wr_en`, and flips `sweep_mode`, in the middle of runs. These pulses exercise the rules that the engine ignores such inputs while busy.

// File: rtl/tsum_pkg.sv
package tsum_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PASS = 2'd1,
        ST_DONE = 2'd2
    } tsum_state_e;

    typedef enum logic {
        SWEEP_HALVING     = 1'b0,
        SWEEP_INTERLEAVED = 1'b1
    } tsum_sweep_e;

endpackage

// File: rtl/tsum_ctrl.sv
module tsum_ctrl
    import tsum_pkg::*;
#(
    parameter int N = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          sweep_in,
    output tsum_sweep_e   sweep_q,
    output logic [$clog2(N)-1:0] stride_q,
    output logic          busy,
    output logic          done,
    output logic          run
);
    localparam int AW   = $clog2(N);
    localparam int HALF = N / 2;

    tsum_state_e state_q, state_d;
    logic        last_pass;

    assign last_pass = (sweep_q == SWEEP_INTERLEAVED) ? (stride_q == AW'(HALF))
                                                      : (stride_q == AW'(1));

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)     state_d = ST_PASS;
            ST_PASS: if (last_pass) state_d = ST_DONE;
            ST_DONE:                state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Stride schedule and latched sweep choice
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sweep_q  <= SWEEP_HALVING;
            stride_q <= '0;
        end else if (state_q == ST_IDLE && start) begin
            sweep_q  <= tsum_sweep_e'(sweep_in);
            stride_q <= sweep_in ? AW'(1) : AW'(HALF);
        end else if (state_q == ST_PASS) begin
            stride_q <= (sweep_q == SWEEP_INTERLEAVED) ? (stride_q << 1) : (stride_q >> 1);
        end
    end

    // Outputs
    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        run  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_PASS: begin busy = 1'b1; run = 1'b1; end
            ST_DONE: begin busy = 1'b1; done = 1'b1; end
            default: ;
        endcase
    end
endmodule

// File: rtl/tsum_lanes.sv
module tsum_lanes
    import tsum_pkg::*;
#(
    parameter int N     = 8,
    parameter int SUM_W = 11
) (
    input  tsum_sweep_e                       sweep,
    input  logic [$clog2(N)-1:0]              stride,
    input  logic [N-1:0][SUM_W-1:0]           slots,
    output logic [N/2-1:0]                    act,
    output logic [N/2-1:0][$clog2(N)-1:0]     dst,
    output logic [N/2-1:0][SUM_W-1:0]         sum
);
    localparam int AW = $clog2(N);
    localparam int NL = N / 2;

    for (genvar l = 0; l < NL; l++) begin : g_lane
        logic [AW:0] dst_x, src_x;
        always_comb begin
            if (sweep == SWEEP_INTERLEAVED) begin
                dst_x  = (AW+1)'(2 * l);
                act[l] = ((AW'(l) & (stride - AW'(1))) == '0);
            end else begin
                dst_x  = (AW+1)'(l);
                act[l] = (AW'(l) < stride);
            end
            src_x  = dst_x + {1'b0, stride};
            dst[l] = dst_x[AW-1:0];
            sum[l] = slots[dst_x[AW-1:0]] + slots[src_x[AW-1:0]];
        end
    end
endmodule

// File: rtl/tsum_buffer.sv
module tsum_buffer #(
    parameter int N      = 8,
    parameter int DATA_W = 8,
    parameter int SUM_W  = 11
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_ok,
    input  logic [$clog2(N)-1:0]              wr_addr,
    input  logic [DATA_W-1:0]                 wr_data,
    input  logic                              upd_en,
    input  logic [N/2-1:0]                    act,
    input  logic [N/2-1:0][$clog2(N)-1:0]     dst,
    input  logic [N/2-1:0][SUM_W-1:0]         sum,
    output logic [N-1:0][SUM_W-1:0]           slots
);
    localparam int NL = N / 2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slots <= '0;
        end else if (wr_ok) begin
            slots[wr_addr] <= SUM_W'(wr_data);
        end else if (upd_en) begin
            for (int l = 0; l < NL; l++) begin
                if (act[l]) slots[dst[l]] <= sum[l];
            end
        end
    end
endmodule

// File: rtl/tsum_group_stats.sv
module tsum_group_stats #(
    parameter int NL    = 4,
    parameter int GROUP = 2
) (
    input  logic                          valid,
    input  logic [NL-1:0]                 act,
    output logic [$clog2(NL/GROUP+1)-1:0] idle_cnt,
    output logic [$clog2(NL/GROUP+1)-1:0] partial_cnt
);
    localparam int NG = NL / GROUP;
    localparam int CW = $clog2(NG + 1);

    logic [NG-1:0] g_any, g_all;

    for (genvar g = 0; g < NG; g++) begin : g_grp
        assign g_any[g] = |act[g*GROUP +: GROUP];
        assign g_all[g] = &act[g*GROUP +: GROUP];
    end

    always_comb begin
        idle_cnt    = '0;
        partial_cnt = '0;
        if (valid) begin
            for (int g = 0; g < NG; g++) begin
                idle_cnt    = idle_cnt    + CW'(!g_any[g]);
                partial_cnt = partial_cnt + CW'(g_any[g] && !g_all[g]);
            end
        end
    end
endmodule

// File: rtl/tree_sum_engine.sv
module tree_sum_engine
    import tsum_pkg::*;
#(
    parameter int N      = 8,
    parameter int DATA_W = 8,
    parameter int GROUP  = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [$clog2(N)-1:0]               wr_addr,
    input  logic [DATA_W-1:0]                  wr_data,
    input  logic                               sweep_mode,
    input  logic                               start,
    output logic                               busy,
    output logic                               done,
    output logic [DATA_W+$clog2(N)-1:0]        total,
    output logic                               pass_valid,
    output logic [$clog2(N/2/GROUP+1)-1:0]     groups_idle,
    output logic [$clog2(N/2/GROUP+1)-1:0]     groups_partial
);
    localparam int AW    = $clog2(N);
    localparam int NL    = N / 2;
    localparam int SUM_W = DATA_W + AW;

    tsum_sweep_e               sweep_q;
    logic [AW-1:0]             stride_q;
    logic                      run;
    logic [N-1:0][SUM_W-1:0]   slots;
    logic [NL-1:0]             act;
    logic [NL-1:0][AW-1:0]     dst;
    logic [NL-1:0][SUM_W-1:0]  sum;

    tsum_ctrl #(.N(N)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .sweep_in (sweep_mode),
        .sweep_q  (sweep_q),
        .stride_q (stride_q),
        .busy     (busy),
        .done     (done),
        .run      (run)
    );

    tsum_lanes #(.N(N), .SUM_W(SUM_W)) u_lanes (
        .sweep  (sweep_q),
        .stride (stride_q),
        .slots  (slots),
        .act    (act),
        .dst    (dst),
        .sum    (sum)
    );

    tsum_buffer #(.N(N), .DATA_W(DATA_W), .SUM_W(SUM_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ok   (wr_en && !busy),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .upd_en  (run),
        .act     (act),
        .dst     (dst),
        .sum     (sum),
        .slots   (slots)
    );

    tsum_group_stats #(.NL(NL), .GROUP(GROUP)) u_stats (
        .valid       (run),
        .act         (act),
        .idle_cnt    (groups_idle),
        .partial_cnt (groups_partial)
    );

    assign total      = slots[0];
    assign pass_valid = run;
endmodule

// File: rtl/tsum_checker.sv
module tsum_checker #(
    parameter int N      = 8,
    parameter int DATA_W = 8,
    parameter int GROUP  = 2
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               wr_en,
    input logic                               start,
    input logic                               busy,
    input logic                               done,
    input logic                               pass_valid,
    input logic [DATA_W+$clog2(N)-1:0]        total,
    input logic [$clog2(N/2/GROUP+1)-1:0]     groups_idle,
    input logic [$clog2(N/2/GROUP+1)-1:0]     groups_partial
);
    localparam int NG = N / 2 / GROUP;

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !wr_en) |=> $stable(total));

    p_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && pass_valid));

    p_done_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy && !pass_valid));

    p_done_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    p_group_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pass_valid |-> (32'(groups_idle) + 32'(groups_partial) <= NG));

    p_group_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !pass_valid |-> (groups_idle == '0 && groups_partial == '0));

    p_run_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind tree_sum_engine tsum_checker #(.N(N), .DATA_W(DATA_W), .GROUP(GROUP)) u_tsum_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .start          (start),
    .busy           (busy),
    .done           (done),
    .pass_valid     (pass_valid),
    .total          (total),
    .groups_idle    (groups_idle),
    .groups_partial (groups_partial)
);

// File: tb/tb_tree_sum_engine.sv
`timescale 1ns/1ps
module tb_tree_sum_engine;
    localparam int N      = 8;
    localparam int DATA_W = 8;
    localparam int GROUP  = 2;
    localparam int AW     = $clog2(N);
    localparam int L      = AW;
    localparam int NL     = N / 2;
    localparam int NG     = NL / GROUP;
    localparam int CW     = $clog2(NG + 1);
    localparam int NV     = 5;

    localparam logic [DATA_W-1:0] VEC [NV][N] = '{
        '{8'd0,   8'd1,   8'd5,   8'd2,   8'd3,   8'd4,   8'd6,   8'd7},
        '{8'd0,   8'd1,   8'd5,   8'd2,   8'd3,   8'd4,   8'd6,   8'd7},
        '{8'd255, 8'd255, 8'd255, 8'd255, 8'd255, 8'd255, 8'd255, 8'd255},
        '{8'd1,   8'd0,   8'd0,   8'd0,   8'd0,   8'd0,   8'd0,   8'd200},
        '{8'd17,  8'd99,  8'd3,   8'd128, 8'd64,  8'd250, 8'd9,   8'd42}
    };
    localparam logic VMODE [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic sweep_mode = 1'b0;
    logic start = 1'b0;
    logic busy, done, pass_valid;
    logic [DATA_W+AW-1:0] total;
    logic [CW-1:0] groups_idle, groups_partial;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    logic [DATA_W-1:0] cur [N];

    always #2 clk = ~clk;

    tree_sum_engine #(.N(N), .DATA_W(DATA_W), .GROUP(GROUP)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sweep_mode(sweep_mode), .start(start), .busy(busy), .done(done), .total(total),
        .pass_valid(pass_valid), .groups_idle(groups_idle), .groups_partial(groups_partial)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected group counts from the lane activity rules
    task automatic exp_groups(input logic m, input int p, output int idle, output int part);
        int s;
        s = m ? (1 << p) : ((N / 2) >> p);
        idle = 0;
        part = 0;
        for (int g = 0; g < NG; g++) begin
            int na;
            na = 0;
            for (int k = 0; k < GROUP; k++) begin
                int t;
                t = g * GROUP + k;
                if (m ? ((2 * t) % (2 * s) == 0) : (t < s)) na++;
            end
            if (na == 0) idle++;
            else if (na < GROUP) part++;
        end
    endtask

    task automatic load_cur();
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = AW'(i); wr_data = cur[i];
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // disturb: 0 none, 1 start pulse, 2 write to slot 0, 3 flip sweep_mode (all during pass 1)
    task automatic run_case(input logic m, input int disturb);
        int sum, ei, ep;
        sum = 0;
        for (int i = 0; i < N; i++) sum += cur[i];
        load_cur();
        sweep_mode = m;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int p = 0; p < L; p++) begin
            if (p > 0) begin
                @(negedge clk);
                start = 1'b0; wr_en = 1'b0; sweep_mode = m;
            end
            exp_groups(m, p, ei, ep);
            chk("R4 pass_valid", pass_valid, 1);
            chk("R4 busy", busy, 1);
            chk("R9 done low in pass", done, 0);
            chk(m ? "R6 R7 groups_idle" : "R5 R7 groups_idle", groups_idle, ei);
            chk(m ? "R6 R7 groups_partial" : "R5 R7 groups_partial", groups_partial, ep);
            if (p == 1) begin
                if (disturb == 1) start = 1'b1;
                if (disturb == 2) begin wr_en = 1'b1; wr_addr = '0; wr_data = 8'hFF; end
                if (disturb == 3) sweep_mode = ~m;
            end
        end
        @(negedge clk);
        start = 1'b0; wr_en = 1'b0; sweep_mode = m;
        chk("R4 done", done, 1);
        chk("R4 pass_valid end", pass_valid, 0);
        chk(disturb == 2 ? "R8 total" : "R3 total", total, sum);
        @(negedge clk);
        chk("R9 done pulse", done, 0);
        chk(disturb == 1 ? "R8 busy" : "R4 busy idle", busy, 0);
        @(negedge clk);
        chk("R8 no second run", pass_valid, 0);
        chk("R3 total held", total, sum);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 pass_valid", pass_valid, 0);
        chk("R1 total", total, 0);
        chk("R1 groups_idle", groups_idle, 0);
        chk("R1 groups_partial", groups_partial, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 write port and slot 0 visibility
        wr_en = 1'b1; wr_addr = '0; wr_data = 8'h5A;
        @(negedge clk);
        wr_addr = AW'(3); wr_data = 8'h11;
        chk("R2 slot0 write", total, 8'h5A);
        @(negedge clk);
        wr_en = 1'b0;
        chk("R2 other slot", total, 8'h5A);

        // Table-driven runs (R3, R5, R6, R7)
        for (int v = 0; v < NV; v++) begin
            for (int i = 0; i < N; i++) cur[i] = VEC[v][i];
            run_case(VMODE[v], 0);
        end

        // Directed: ignored inputs during a run (R8, R10)
        for (int i = 0; i < N; i++) cur[i] = VEC[4][i];
        run_case(1'b0, 1);
        run_case(1'b1, 1);
        run_case(1'b0, 2);
        run_case(1'b0, 3);
        run_case(1'b1, 3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule